// File: doc/BRIEF.md
# Keyboard Character Receive Buffer

This block takes the two open-collector lines of a PS/2 keyboard and turns key presses into ASCII characters that a host can collect. The keyboard drives the clock line. The block brings both lines into the system clock domain, finds the falling edges of the keyboard clock and assembles 11-bit frames from them. It decodes each received scan code set 2 byte, removes key-release and extended sequences, and translates make codes for letters, digits, space and enter into ASCII. The resulting characters go into a small circular store.

The host reads characters one at a time with a four-phase handshake. It raises a request line. The block then presents the oldest character and raises an acknowledge. The entry is released only when the host drops its request. A separate level output reports whether any character is waiting, so the host can poll before it starts a read.

Top module: `ps2_char_buffer`

## Requirements
- R1: After reset, `buf_empty_o` is 1, `rd_complete_o` is 0 and no character is stored.
- R2: The block accepts a frame of 11 bits, each sampled on a falling edge of the keyboard clock. The frame is a start bit of 0, eight data bits sent least significant bit first, an odd parity bit and a stop bit of 1. A valid frame with a letter make code stores the lowercase ASCII letter (for example code 0x1C gives 0x61 and 0x1A gives 0x7A).
- R3: Digit make codes store ASCII `0` to `9` (0x45 gives 0x30, 0x16 gives 0x31, 0x46 gives 0x39). Code 0x29 (space) stores 0x20 and code 0x5A (enter) stores 0x0D.
- R4: A frame with wrong parity or with a stop bit of 0 stores nothing.
- R5: After the release prefix 0xF0, the next byte is discarded and stores nothing.
- R6: After the extended prefix 0xE0, the next non-prefix byte is discarded, including an 0xE0 0xF0 xx release sequence.
- R7: A valid byte that has no translation stores nothing.
- R8: When `rd_valid_i` is high and a character is stored, `rd_complete_o` rises with the oldest character on `rd_char_o`. The character stays stored, and `buf_empty_o` stays 0, until `rd_valid_i` falls. Then `rd_complete_o` falls and the entry is released.
- R9: While `rd_valid_i` stays high after a completion, no further character is delivered, and `rd_char_o` holds steady.
- R10: Characters are read in arrival order. Once DEPTH characters are stored, further characters are dropped until an entry is released.
- R11: A request made while the store is empty keeps `rd_complete_o` low until a character arrives, and then completes with that character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kb_clk_i | input | 1 | Keyboard clock line (idle high) |
| kb_dat_i | input | 1 | Keyboard data line (idle high) |
| rd_valid_i | input | 1 | Host read request |
| rd_complete_o | output | 1 | Read acknowledge; character valid while high |
| rd_char_o | output | 8 | ASCII character being delivered |
| buf_empty_o | output | 1 | High when no character is stored |

## Verification
A corrupted write or read pointer shows up at once on `buf_empty_o`, or as a wrong or repeated character in the next handshake. The bench therefore compares every delivered character against a queue of expected ones and checks the empty level after each rejected sequence. A stuck release or extended flag swallows the next good key, and a wrong bit count shifts every following character. Both are caught within one frame by the scoreboard compare. Handshake faults, such as an acknowledge without a request or a release while the request is still high, are caught within one system clock by the bound checker.

// File: rtl/ps2kb_pkg.sv
package ps2kb_pkg;

    localparam logic [7:0] CODE_RELEASE  = 8'hF0;
    localparam logic [7:0] CODE_EXTENDED = 8'hE0;

    typedef struct packed {
        logic brk;
        logic ext;
    } xlate_st_t;

    // Scan code set 2 make code to ASCII; 0 means no translation.
    function automatic logic [7:0] scan_to_ascii(input logic [7:0] sc);
        logic [7:0] a;
        case (sc)
            8'h1C: a = 8'h61; 8'h32: a = 8'h62; 8'h21: a = 8'h63; 8'h23: a = 8'h64;
            8'h24: a = 8'h65; 8'h2B: a = 8'h66; 8'h34: a = 8'h67; 8'h33: a = 8'h68;
            8'h43: a = 8'h69; 8'h3B: a = 8'h6A; 8'h42: a = 8'h6B; 8'h4B: a = 8'h6C;
            8'h3A: a = 8'h6D; 8'h31: a = 8'h6E; 8'h44: a = 8'h6F; 8'h4D: a = 8'h70;
            8'h15: a = 8'h71; 8'h2D: a = 8'h72; 8'h1B: a = 8'h73; 8'h2C: a = 8'h74;
            8'h3C: a = 8'h75; 8'h2A: a = 8'h76; 8'h1D: a = 8'h77; 8'h22: a = 8'h78;
            8'h35: a = 8'h79; 8'h1A: a = 8'h7A;
            8'h45: a = 8'h30; 8'h16: a = 8'h31; 8'h1E: a = 8'h32; 8'h26: a = 8'h33;
            8'h25: a = 8'h34; 8'h2E: a = 8'h35; 8'h36: a = 8'h36; 8'h3D: a = 8'h37;
            8'h3E: a = 8'h38; 8'h46: a = 8'h39;
            8'h29: a = 8'h20;
            8'h5A: a = 8'h0D;
            default: a = 8'h00;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/kbd_frame_rx.sv
module kbd_frame_rx #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       kb_clk_i,
    input  logic       kb_dat_i,
    output logic       byte_vld_o,
    output logic [7:0] byte_o
);
    localparam int FRAME_BITS = 11;
    localparam int CW         = $clog2(FRAME_BITS);
    localparam logic [CW-1:0] LAST_DATA = CW'(8);
    localparam logic [CW-1:0] PAR_BIT   = CW'(9);
    localparam logic [CW-1:0] STOP_BIT  = CW'(FRAME_BITS - 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] kc_sync;
        logic [SYNC_STAGES-1:0] kd_sync;
        logic                   kc_prev;
        logic [CW-1:0]          cnt;
        logic [7:0]             sh;
        logic                   par;
        logic [7:0]             dout;
        logic                   vld;
    } rx_st_t;

    rx_st_t s_q, s_d;
    logic kc, kd, fall;

    always_comb begin
        s_d = s_q;
        s_d.vld = 1'b0;
        s_d.kc_sync = {s_q.kc_sync[SYNC_STAGES-2:0], kb_clk_i};
        s_d.kd_sync = {s_q.kd_sync[SYNC_STAGES-2:0], kb_dat_i};
        kc = s_q.kc_sync[SYNC_STAGES-1];
        kd = s_q.kd_sync[SYNC_STAGES-1];
        s_d.kc_prev = kc;
        fall = s_q.kc_prev & ~kc;
        if (fall) begin
            if (s_q.cnt == '0) begin
                if (!kd) s_d.cnt = CW'(1);
            end else if (s_q.cnt <= LAST_DATA) begin
                s_d.sh  = {kd, s_q.sh[7:1]};
                s_d.cnt = s_q.cnt + CW'(1);
            end else if (s_q.cnt == PAR_BIT) begin
                s_d.par = kd;
                s_d.cnt = STOP_BIT;
            end else begin
                s_d.cnt = '0;
                if (kd && (^{s_q.sh, s_q.par})) begin
                    s_d.dout = s_q.sh;
                    s_d.vld  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.kc_sync <= '1;
            s_q.kd_sync <= '1;
            s_q.kc_prev <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign byte_vld_o = s_q.vld;
    assign byte_o     = s_q.dout;
endmodule

// File: rtl/kbd_scan_xlate.sv
module kbd_scan_xlate
    import ps2kb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_vld_i,
    input  logic [7:0] byte_i,
    output logic       push_o,
    output logic [7:0] char_o
);
    xlate_st_t s_q, s_d;
    logic [7:0] asc;

    always_comb begin
        s_d    = s_q;
        asc    = scan_to_ascii(byte_i);
        push_o = 1'b0;
        if (byte_vld_i) begin
            if (byte_i == CODE_RELEASE) begin
                s_d.brk = 1'b1;
            end else if (byte_i == CODE_EXTENDED) begin
                s_d.ext = 1'b1;
            end else begin
                s_d.brk = 1'b0;
                s_d.ext = 1'b0;
                push_o  = !s_q.brk && !s_q.ext && (asc != 8'h00);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign char_o = asc;
endmodule

// File: rtl/kbd_hs_fifo.sv
module kbd_hs_fifo #(
    parameter int DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push_i,
    input  logic [7:0] char_i,
    input  logic       rd_valid_i,
    output logic       rd_complete_o,
    output logic [7:0] rd_char_o,
    output logic       empty_o
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW:0] wp;
        logic [AW:0] rp;
        logic        cmp;
        logic [7:0]  ch;
    } fifo_st_t;

    fifo_st_t s_q, s_d;
    logic [7:0] mem_q [DEPTH];
    logic full, empty, wr_en;

    always_comb begin
        s_d   = s_q;
        empty = (s_q.wp == s_q.rp);
        full  = (s_q.wp[AW] != s_q.rp[AW]) && (s_q.wp[AW-1:0] == s_q.rp[AW-1:0]);
        wr_en = push_i && !full;
        if (wr_en) s_d.wp = s_q.wp + 1'b1;
        if (!s_q.cmp) begin
            if (rd_valid_i && !empty) begin
                s_d.cmp = 1'b1;
                s_d.ch  = mem_q[s_q.rp[AW-1:0]];
            end
        end else if (!rd_valid_i) begin
            s_d.cmp = 1'b0;
            s_d.rp  = s_q.rp + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[s_q.wp[AW-1:0]] <= char_i;
    end

    assign rd_complete_o = s_q.cmp;
    assign rd_char_o     = s_q.ch;
    assign empty_o       = empty;
endmodule

// File: rtl/ps2_char_buffer.sv
module ps2_char_buffer #(
    parameter int DEPTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       kb_clk_i,
    input  logic       kb_dat_i,
    input  logic       rd_valid_i,
    output logic       rd_complete_o,
    output logic [7:0] rd_char_o,
    output logic       buf_empty_o
);
    logic       byte_vld;
    logic [7:0] byte_val;
    logic       push;
    logic [7:0] push_char;

    kbd_frame_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk(clk), .rst_n(rst_n), .kb_clk_i(kb_clk_i), .kb_dat_i(kb_dat_i),
        .byte_vld_o(byte_vld), .byte_o(byte_val)
    );

    kbd_scan_xlate u_xl (
        .clk(clk), .rst_n(rst_n), .byte_vld_i(byte_vld), .byte_i(byte_val),
        .push_o(push), .char_o(push_char)
    );

    kbd_hs_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push_i(push), .char_i(push_char),
        .rd_valid_i(rd_valid_i), .rd_complete_o(rd_complete_o),
        .rd_char_o(rd_char_o), .empty_o(buf_empty_o)
    );
endmodule

// File: rtl/ps2_char_buffer_chk.sv
module ps2_char_buffer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_valid_i,
    input logic       rd_complete_o,
    input logic [7:0] rd_char_o,
    input logic       buf_empty_o
);
    a_r8_ack_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_complete_o) |-> $past(rd_valid_i));

    a_r8_release_after_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_complete_o) |-> !$past(rd_valid_i));

    a_r8_held_entry_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        rd_complete_o |-> !buf_empty_o);

    a_r9_char_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_complete_o && $past(rd_complete_o)) |-> $stable(rd_char_o));

    a_r11_no_ack_from_empty: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_complete_o) |-> !$past(buf_empty_o));
endmodule

bind ps2_char_buffer ps2_char_buffer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rd_valid_i(rd_valid_i),
    .rd_complete_o(rd_complete_o), .rd_char_o(rd_char_o),
    .buf_empty_o(buf_empty_o)
);

// File: tb/sim_ps2_char_buffer.sv
module sim_ps2_char_buffer;
    localparam int DEPTH = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic kb_clk = 1'b1;
    logic kb_dat = 1'b1;
    logic rd_valid = 1'b0;
    logic rd_complete;
    logic [7:0] rd_char;
    logic buf_empty;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];

    always #4 clk = ~clk;

    ps2_char_buffer #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .kb_clk_i(kb_clk), .kb_dat_i(kb_dat),
        .rd_valid_i(rd_valid), .rd_complete_o(rd_complete),
        .rd_char_o(rd_char), .buf_empty_o(buf_empty)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic kb_bit(input logic b);
        @(negedge clk) kb_dat = b;
        repeat (20) @(negedge clk);
        kb_clk = 1'b0;
        repeat (40) @(negedge clk);
        kb_clk = 1'b1;
        repeat (20) @(negedge clk);
    endtask

    // Driver: sends one frame; pushes the expected character when one is due.
    task automatic send(input logic [7:0] code, input bit bad_par, input bit bad_stop,
                        input bit expect_it, input logic [7:0] exp_ch);
        kb_bit(1'b0);
        for (int i = 0; i < 8; i++) kb_bit(code[i]);
        kb_bit(~(^code) ^ bad_par);
        kb_bit(~bad_stop);
        @(negedge clk) kb_dat = 1'b1;
        repeat (30) @(negedge clk);
        if (expect_it) exp_q.push_back(exp_ch);
    endtask

    // Monitor: one handshake, compared against the scoreboard queue.
    task automatic read_one(input string req);
        logic [7:0] e;
        int n;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
        @(negedge clk) rd_valid = 1'b1;
        n = 0;
        while (!rd_complete && n < 2000) begin @(negedge clk); n++; end
        chk(rd_complete == 1'b1, req, rd_complete, 1);
        chk(rd_char === e, req, rd_char, e);
        @(negedge clk) rd_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(rd_complete == 1'b0, req, rd_complete, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(buf_empty == 1'b1, "R1 empty", buf_empty, 1);
        chk(rd_complete == 1'b0, "R1 complete", rd_complete, 0);

        send(8'h1C, 0, 0, 1, 8'h61);
        chk(buf_empty == 1'b0, "R2 stored", buf_empty, 0);
        read_one("R2 letter a");
        chk(buf_empty == 1'b1, "R8 released", buf_empty, 1);

        send(8'h1A, 0, 0, 1, 8'h7A);
        send(8'h45, 0, 0, 1, 8'h30);
        send(8'h46, 0, 0, 1, 8'h39);
        send(8'h29, 0, 0, 1, 8'h20);
        send(8'h5A, 0, 0, 1, 8'h0D);
        read_one("R2 letter z");
        read_one("R3 digit 0");
        read_one("R3 digit 9");
        read_one("R3 space");
        read_one("R3 enter");
        chk(buf_empty == 1'b1, "R3 drained", buf_empty, 1);

        send(8'h1C, 1, 0, 0, 8'h00);
        chk(buf_empty == 1'b1, "R4 bad parity", buf_empty, 1);
        send(8'h1C, 0, 1, 0, 8'h00);
        chk(buf_empty == 1'b1, "R4 bad stop", buf_empty, 1);

        send(8'hF0, 0, 0, 0, 8'h00);
        send(8'h1C, 0, 0, 0, 8'h00);
        chk(buf_empty == 1'b1, "R5 release", buf_empty, 1);

        send(8'hE0, 0, 0, 0, 8'h00);
        send(8'h1C, 0, 0, 0, 8'h00);
        chk(buf_empty == 1'b1, "R6 extended", buf_empty, 1);
        send(8'hE0, 0, 0, 0, 8'h00);
        send(8'hF0, 0, 0, 0, 8'h00);
        send(8'h1C, 0, 0, 0, 8'h00);
        chk(buf_empty == 1'b1, "R6 extended release", buf_empty, 1);

        send(8'h76, 0, 0, 0, 8'h00);
        chk(buf_empty == 1'b1, "R7 unmapped", buf_empty, 1);
        send(8'h15, 0, 0, 1, 8'h71);
        read_one("R5 R6 R7 next key kept");

        // R9: hold the request high after completion
        send(8'h32, 0, 0, 1, 8'h62);
        send(8'h21, 0, 0, 1, 8'h63);
        @(negedge clk) rd_valid = 1'b1;
        repeat (5) @(negedge clk);
        chk(rd_complete == 1'b1, "R8 ack", rd_complete, 1);
        chk(rd_char == exp_q[0], "R8 char", rd_char, exp_q[0]);
        repeat (50) @(negedge clk);
        chk(rd_complete == 1'b1, "R9 still held", rd_complete, 1);
        chk(rd_char == exp_q[0], "R9 no second char", rd_char, exp_q[0]);
        chk(buf_empty == 1'b0, "R8 not released early", buf_empty, 0);
        void'(exp_q.pop_front());
        @(negedge clk) rd_valid = 1'b0;
        repeat (3) @(negedge clk);
        read_one("R9 next handshake");
        chk(buf_empty == 1'b1, "R9 drained", buf_empty, 1);

        // R10: overfill
        for (int k = 0; k < DEPTH + 2; k++) begin
            logic [7:0] cd;
            cd = (k % 2 == 0) ? 8'h24 : 8'h2B;
            send(cd, 0, 0, (k < DEPTH), (k % 2 == 0) ? 8'h65 : 8'h66);
        end
        for (int k = 0; k < DEPTH; k++) read_one("R10 order");
        chk(buf_empty == 1'b1, "R10 extras dropped", buf_empty, 1);

        // R11: request while empty
        @(negedge clk) rd_valid = 1'b1;
        repeat (20) @(negedge clk);
        chk(rd_complete == 1'b0, "R11 waits", rd_complete, 0);
        @(negedge clk) rd_valid = 1'b0;
        send(8'h44, 0, 0, 1, 8'h6F);
        read_one("R11 late char");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule